// File: doc/BRIEF.md
# Chip-Select Address Window Decoder

This block sits between a memory-mapped bus and a set of serial flash devices. Every bus address that falls inside the flash window is mapped to one chip select, together with the byte offset of the address inside that chip select's region. Each chip select owns one segment register, and a shared configuration register holds a device-type field and a write-enable bit for each chip select. Register access goes through a simple single-cycle port. The decode itself is combinational, and it reads the registered segment and configuration values.

Two segment encodings exist, and a parameter picks one for each instance. The coarse encoding stores the region bounds as absolute addresses in 8 MB units, and its end bound is exclusive. The fine encoding stores the bounds as 1 MB offsets from the window base, and its end bound is inclusive. In the fine encoding an end field of zero turns the region off. A write that lands in a region whose write enable is clear is dropped and reported. Reads are never gated.

Top module: `cswin_decoder`

## Requirements
- R1: After reset the configuration register reads 0. Chip select 0 covers the bottom of the window: segment value `{base_unit+1, base_unit, 16'h0}` in coarse mode, where base_unit is window-base bits 30:23, and `32'h0010_0000` (start 0 MB, end field 1 giving 0 to 2 MB) in fine mode. Every other segment register reads 0, which is a closed region.
- R2: The configuration register sits at offset 0x00. Bits 2n+1:2n hold the type of chip select n (2 means serial flash), and bit 16+n is its write enable. The segment register of chip select n sits at offset 0x30+4n. A read returns the stored value with the unimplemented bits as 0. Coarse segments keep bits 31:16, fine segments keep bits 27:20 and 11:4, and the configuration register keeps only the fields listed here. Other offsets read 0.
- R3: Coarse mode. The region of chip select n is [start·8 MB, end·8 MB) in absolute bus addresses, with start in bits 23:16 and end in bits 31:24. A region with start equal to end is empty.
- R4: Fine mode. The region is [base + start·1 MB, base + end·1 MB + 1 MB), with start in bits 11:4 and end in bits 27:20.
- R5: Fine mode. An end field of 0 disables the region whatever the start field holds, so an all-zero segment value selects nothing.
- R6: When regions overlap, the lowest-numbered chip select that hits wins. `sel_oh` is one-hot at bit n and `sel_cs` equals n.
- R7: A valid access that hits no region raises `miss` and selects nothing.
- R8: A valid write that hits a region whose write-enable bit is clear is dropped: `wr_err` rises and `sel_oh`, `sel_cs` and `win_off` stay 0. The same access as a read is selected normally.
- R9: For a selected access, `win_off` equals the bus address minus the start address of the winning region.
- R10: While `bus_valid` is low, `sel_oh`, `sel_cs`, `win_off`, `miss` and `wr_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| bus_valid | input | 1 | Access present on the bus |
| bus_write | input | 1 | Access is a write |
| bus_addr | input | 32 | Bus byte address |
| sel_cs | output | CS_W (3) | Index of the selected chip select |
| sel_oh | output | NUM_CS (5) | One-hot chip-select strobe |
| win_off | output | 32 | Offset inside the selected region |
| miss | output | 1 | Valid access outside every open region |
| wr_err | output | 1 | Valid write refused by a cleared write enable |

## Verification
The assertions assume that `rst_n` is held low before the first clock edge. They also assume that `bus_write` means something only when `bus_valid` is high, and that the bus and register inputs settle between edges rather than at them. The stimulus changes every input one time unit after a rising edge and compares the outputs on the falling edge. It drives the coarse and fine instances with the same bus traffic but gives each its own segment data. Random addresses stay inside a 48 MB span above the window base, and random segment values are stored through the normal register port. Because of this, regions open, close, overlap and invert while traffic runs.

// File: rtl/cswin_pkg.sv
package cswin_pkg;

    localparam logic [7:0]  CFG_OFS         = 8'h00;
    localparam logic [7:0]  SEG_OFS0        = 8'h30;
    localparam int unsigned WE_LSB          = 16;
    localparam logic [31:0] COARSE_SEG_MASK = 32'hFFFF_0000;
    localparam logic [31:0] FINE_SEG_MASK   = 32'h0FF0_0FF0;
    localparam logic [32:0] FINE_UNIT       = 33'h0_0010_0000;

    function automatic logic [7:0] seg_ofs(input int unsigned n);
        return SEG_OFS0 + 8'(4 * n);
    endfunction

    function automatic logic [31:0] cfg_mask(input int unsigned ncs);
        logic [31:0] m;
        m = '0;
        for (int unsigned i = 0; i < ncs; i++) begin
            m[2*i +: 2]      = 2'b11;
            m[WE_LSB + i]    = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/cswin_regs.sv
module cswin_regs #(
    parameter int unsigned NUM_CS   = 5,
    parameter bit          FINE_ENC = 1'b0,
    parameter logic [31:0] WIN_BASE = 32'h2000_0000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     reg_we,
    input  logic [7:0]               reg_addr,
    input  logic [31:0]              reg_wdata,
    output logic [31:0]              reg_rdata,
    output logic [31:0]              cfg_o,
    output logic [NUM_CS-1:0][31:0]  seg_o
);
    import cswin_pkg::*;

    localparam logic [31:0] SEG_MASK  = FINE_ENC ? FINE_SEG_MASK : COARSE_SEG_MASK;
    localparam logic [31:0] CFG_MASK  = cfg_mask(NUM_CS);
    localparam logic [7:0]  BASE_UNIT = WIN_BASE[30:23];
    localparam logic [31:0] CS0_RST   = FINE_ENC ? 32'h0010_0000
                                                 : {BASE_UNIT + 8'd1, BASE_UNIT, 16'h0000};

    typedef struct packed {
        logic [31:0]             cfg;
        logic [NUM_CS-1:0][31:0] seg;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d       = r_q;
        reg_rdata = '0;
        if (reg_addr == CFG_OFS) begin
            reg_rdata = r_q.cfg;
            if (reg_we) r_d.cfg = reg_wdata & CFG_MASK;
        end
        for (int unsigned n = 0; n < NUM_CS; n++) begin
            if (reg_addr == seg_ofs(n)) begin
                reg_rdata = r_q.seg[n];
                if (reg_we) r_d.seg[n] = reg_wdata & SEG_MASK;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.cfg <= '0;
            for (int unsigned n = 0; n < NUM_CS; n++)
                r_q.seg[n] <= (n == 0) ? CS0_RST : 32'h0;
        end else begin
            r_q <= r_d;
        end
    end

    assign cfg_o = r_q.cfg;
    assign seg_o = r_q.seg;

endmodule

// File: rtl/cswin_range.sv
module cswin_range #(
    parameter bit          FINE_ENC = 1'b0,
    parameter logic [31:0] WIN_BASE = 32'h2000_0000
) (
    input  logic [31:0] seg,
    input  logic [31:0] addr,
    output logic        hit,
    output logic [31:0] lo
);
    import cswin_pkg::*;

    logic [32:0] lo_w, hi_w;
    logic        open_w;

    generate
        if (FINE_ENC) begin : g_fine
            always_comb begin
                lo_w   = {1'b0, WIN_BASE} + {13'b0, seg[11:4], 12'b0, 8'b0};
                hi_w   = {1'b0, WIN_BASE} + {5'b0, seg[27:20], 20'b0} + FINE_UNIT;
                open_w = (seg[27:20] != 8'h00);
            end
        end else begin : g_coarse
            always_comb begin
                lo_w   = {2'b0, seg[23:16], 23'b0};
                hi_w   = {2'b0, seg[31:24], 23'b0};
                open_w = 1'b1;
            end
        end
    endgenerate

    assign hit = open_w && ({1'b0, addr} >= lo_w) && ({1'b0, addr} < hi_w);
    assign lo  = lo_w[31:0];

endmodule

// File: rtl/cswin_pick.sv
module cswin_pick #(
    parameter int unsigned NUM_CS = 5,
    parameter int unsigned CS_W   = 3
) (
    input  logic [NUM_CS-1:0] hit,
    output logic [CS_W-1:0]   idx,
    output logic              found
);
    always_comb begin
        idx   = '0;
        found = 1'b0;
        for (int n = NUM_CS - 1; n >= 0; n--) begin
            if (hit[n]) begin
                idx   = CS_W'(n);
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/cswin_decoder.sv
module cswin_decoder #(
    parameter int unsigned NUM_CS   = 5,
    parameter bit          FINE_ENC = 1'b0,
    parameter logic [31:0] WIN_BASE = 32'h2000_0000,
    parameter int unsigned CS_W     = $clog2(NUM_CS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [7:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [31:0]       bus_addr,
    output logic [CS_W-1:0]   sel_cs,
    output logic [NUM_CS-1:0] sel_oh,
    output logic [31:0]       win_off,
    output logic              miss,
    output logic              wr_err
);
    import cswin_pkg::*;

    logic [31:0]             cfg_q;
    logic [NUM_CS-1:0][31:0] seg_q;
    logic [NUM_CS-1:0]       hit;
    logic [NUM_CS-1:0][31:0] lo;
    logic [CS_W-1:0]         idx;
    logic                    found;
    logic                    blocked;
    logic                    grant;

    cswin_regs #(.NUM_CS(NUM_CS), .FINE_ENC(FINE_ENC), .WIN_BASE(WIN_BASE)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cfg_o(cfg_q), .seg_o(seg_q)
    );

    generate
        for (genvar g = 0; g < NUM_CS; g++) begin : g_win
            cswin_range #(.FINE_ENC(FINE_ENC), .WIN_BASE(WIN_BASE)) u_range (
                .seg(seg_q[g]), .addr(bus_addr), .hit(hit[g]), .lo(lo[g])
            );
        end
    endgenerate

    cswin_pick #(.NUM_CS(NUM_CS), .CS_W(CS_W)) u_pick (
        .hit(hit), .idx(idx), .found(found)
    );

    always_comb begin
        blocked = bus_write && !cfg_q[WE_LSB + int'(idx)];
        grant   = bus_valid && found && !blocked;
        sel_oh  = grant ? (NUM_CS'(1) << idx) : '0;
        sel_cs  = grant ? idx : '0;
        win_off = grant ? (bus_addr - lo[idx]) : '0;
        miss    = bus_valid && !found;
        wr_err  = bus_valid && found && blocked;
    end

endmodule

// File: rtl/cswin_decoder_chk.sv
module cswin_decoder_chk #(
    parameter int unsigned NUM_CS = 5,
    parameter int unsigned CS_W   = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [7:0]        reg_addr,
    input logic [31:0]       reg_rdata,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [CS_W-1:0]   sel_cs,
    input logic [NUM_CS-1:0] sel_oh,
    input logic [31:0]       win_off,
    input logic              miss,
    input logic              wr_err
);
    localparam logic [31:0] CFG_BITS = cswin_pkg::cfg_mask(NUM_CS);

    // R6
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_oh));

    // R6
    sel_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_oh != '0) |-> sel_oh[sel_cs]);

    // R7
    miss_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        miss |-> (sel_oh == '0 && !wr_err));

    // R8
    wr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |-> (bus_write && sel_oh == '0 && win_off == '0 && sel_cs == '0));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid |-> (!miss && !wr_err && sel_oh == '0 && win_off == '0));

    // R7
    one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> ($countones({miss, wr_err, sel_oh != '0}) == 1));

    // R2
    cfg_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 8'h00) |-> ((reg_rdata & ~CFG_BITS) == '0));

endmodule

bind cswin_decoder cswin_decoder_chk #(.NUM_CS(NUM_CS), .CS_W(CS_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
    .bus_valid(bus_valid), .bus_write(bus_write), .sel_cs(sel_cs), .sel_oh(sel_oh),
    .win_off(win_off), .miss(miss), .wr_err(wr_err)
);

// File: tb/cswin_decoder_bench.sv
module cswin_decoder_bench;
    localparam logic [31:0] BASE = 32'h2000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] wd [2];
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [31:0] bus_addr = 32'h0;
    logic [31:0] rd [2];
    logic [2:0]  cs [2];
    logic [4:0]  oh [2];
    logic [31:0] off [2];
    logic        ms [2];
    logic        we_e [2];

    logic [31:0] sh_seg [2][5];
    logic [31:0] sh_cfg [2];
    bit          run = 1'b0;
    int          n_chk = 0;
    int          n_fail = 0;

    always #2 clk = ~clk;

    cswin_decoder #(.FINE_ENC(1'b0), .WIN_BASE(BASE)) u_cswin_decoder (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(wd[0]), .reg_rdata(rd[0]), .bus_valid(bus_valid),
        .bus_write(bus_write), .bus_addr(bus_addr), .sel_cs(cs[0]), .sel_oh(oh[0]),
        .win_off(off[0]), .miss(ms[0]), .wr_err(we_e[0])
    );

    cswin_decoder #(.FINE_ENC(1'b1), .WIN_BASE(BASE)) u_cswin_decoder_fine (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(wd[1]), .reg_rdata(rd[1]), .bus_valid(bus_valid),
        .bus_write(bus_write), .bus_addr(bus_addr), .sel_cs(cs[1]), .sel_oh(oh[1]),
        .win_off(off[1]), .miss(ms[1]), .wr_err(we_e[1])
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // behavioural reference: what each instance must show for the present inputs
    task automatic predict(input int k, output logic [4:0] e_oh, output logic [2:0] e_cs,
                           output logic [31:0] e_off, output logic e_ms,
                           output logic e_we, output logic [31:0] e_rd);
        longint lo, hi, wlo;
        bit     open;
        int     w;
        w = -1; wlo = 0;
        for (int n = 0; n < 5; n++) begin
            if (k == 0) begin
                lo   = longint'(sh_seg[k][n][23:16]) << 23;
                hi   = longint'(sh_seg[k][n][31:24]) << 23;
                open = 1'b1;
            end else begin
                lo   = longint'(BASE) + (longint'(sh_seg[k][n][11:4]) << 20);
                hi   = longint'(BASE) + (longint'(sh_seg[k][n][27:20]) << 20) + 1048576;
                open = sh_seg[k][n][27:20] != 0;
            end
            if (w < 0 && open && longint'(bus_addr) >= lo && longint'(bus_addr) < hi) begin
                w = n; wlo = lo;
            end
        end
        e_oh = 0; e_cs = 0; e_off = 0; e_ms = 0; e_we = 0;
        if (bus_valid) begin
            if (w < 0) e_ms = 1'b1;
            else if (bus_write && !sh_cfg[k][16 + w]) e_we = 1'b1;
            else begin
                e_oh  = 5'(1 << w);
                e_cs  = 3'(w);
                e_off = 32'(longint'(bus_addr) - wlo);
            end
        end
        e_rd = 0;
        if (reg_addr == 8'h00) e_rd = sh_cfg[k];
        for (int n = 0; n < 5; n++)
            if (reg_addr == 8'(8'h30 + 4 * n)) e_rd = sh_seg[k][n];
    endtask

    always @(negedge clk) begin
        if (run) begin
            for (int k = 0; k < 2; k++) begin
                logic [4:0] e_oh; logic [2:0] e_cs; logic [31:0] e_off, e_rd;
                logic e_ms, e_we;
                predict(k, e_oh, e_cs, e_off, e_ms, e_we, e_rd);
                chk("R6 model sel_oh", 32'(oh[k]), 32'(e_oh));
                chk("R6 model sel_cs", 32'(cs[k]), 32'(e_cs));
                chk("R9 model win_off", off[k], e_off);
                chk("R7 model miss", 32'(ms[k]), 32'(e_ms));
                chk("R8 model wr_err", 32'(we_e[k]), 32'(e_we));
                chk("R2 model rdata", rd[k], e_rd);
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] dc, input logic [31:0] df);
        @(posedge clk) #1;
        reg_we = 1'b1; reg_addr = a; wd[0] = dc; wd[1] = df;
        @(posedge clk) #1;
        reg_we = 1'b0;
        if (a == 8'h00) begin
            sh_cfg[0] = dc & 32'h001F_03FF;
            sh_cfg[1] = df & 32'h001F_03FF;
        end
        for (int n = 0; n < 5; n++) begin
            if (a == 8'(8'h30 + 4 * n)) begin
                sh_seg[0][n] = dc & 32'hFFFF_0000;
                sh_seg[1][n] = df & 32'h0FF0_0FF0;
            end
        end
    endtask

    task automatic acc(input logic v, input logic w, input logic [31:0] a);
        @(posedge clk) #1;
        bus_valid = v; bus_write = w; bus_addr = a;
        @(negedge clk);
    endtask

    task automatic rsel(input logic [7:0] a);
        @(posedge clk) #1;
        reg_addr = a;
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 4);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        wd[0] = '0; wd[1] = '0;
        sh_cfg[0] = '0; sh_cfg[1] = '0;
        for (int n = 0; n < 5; n++) begin
            sh_seg[0][n] = '0; sh_seg[1][n] = '0;
        end
        sh_seg[0][0] = 32'h4140_0000;
        sh_seg[1][0] = 32'h0010_0000;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        run = 1'b1;

        // R1 reset state
        rsel(8'h30);
        chk("R1 coarse cs0 segment", rd[0], 32'h4140_0000);
        chk("R1 fine cs0 segment", rd[1], 32'h0010_0000);
        rsel(8'h34);
        chk("R1 cs1 closed", rd[0], 32'h0);
        rsel(8'h00);
        chk("R1 cfg zero", rd[0], 32'h0);
        acc(1'b1, 1'b0, BASE + 32'h0010_0000);
        chk("R1 coarse cs0 open", 32'(oh[0]), 32'h1);
        chk("R1 fine cs0 open", 32'(oh[1]), 32'h1);

        // R2 masked readback
        wr(8'h00, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        rsel(8'h00);
        chk("R2 cfg mask", rd[0], 32'h001F_03FF);
        wr(8'h00, 32'h0002_02AA, 32'h0002_02AA);
        wr(8'h30, 32'h4140_0000, 32'h0080_0080);
        wr(8'h34, 32'h4341_0000, 32'h0030_0020);
        wr(8'h38, 32'h4542_0000, 32'h0000_0000);
        wr(8'h3C, 32'h4646_FFFF, 32'hF050_001F);
        wr(8'h40, 32'h0000_0000, 32'h0090_0090);
        rsel(8'h3C);
        chk("R2 coarse seg mask", rd[0], 32'h4646_0000);
        chk("R2 fine seg mask", rd[1], 32'h0050_0010);

        // R3 / R6 coarse
        acc(1'b1, 1'b0, 32'h2100_0000);
        chk("R6 coarse overlap low wins", 32'(cs[0]), 32'd1);
        chk("R9 coarse offset", off[0], 32'h0080_0000);
        acc(1'b1, 1'b0, 32'h2180_0000);
        chk("R3 coarse end exclusive", 32'(oh[0]), 32'h4);
        acc(1'b1, 1'b0, 32'h2300_0000);
        chk("R7 coarse empty region miss", 32'(ms[0]), 32'h1);

        // R4 / R5 / R6 fine
        acc(1'b1, 1'b0, BASE + 32'h0008_0000);
        chk("R5 fine zero end disabled", 32'(ms[1]), 32'h1);
        acc(1'b1, 1'b0, BASE + 32'h0028_0000);
        chk("R6 fine overlap low wins", 32'(cs[1]), 32'd1);
        chk("R9 fine offset", off[1], 32'h0008_0000);
        acc(1'b1, 1'b0, BASE + 32'h005F_FFFC);
        chk("R4 fine inclusive end", 32'(oh[1]), 32'h8);
        chk("R4 fine offset", off[1], 32'h004F_FFFC);
        acc(1'b1, 1'b0, BASE + 32'h0060_0000);
        chk("R4 fine past end", 32'(ms[1]), 32'h1);

        // R8 write gating
        acc(1'b1, 1'b1, BASE);
        chk("R8 write dropped", 32'(we_e[0]), 32'h1);
        chk("R8 no select", 32'(oh[0]), 32'h0);
        acc(1'b1, 1'b0, BASE);
        chk("R8 read unaffected", 32'(oh[0]), 32'h1);
        acc(1'b1, 1'b1, 32'h2100_0000);
        chk("R8 enabled write", 32'(oh[0]), 32'h2);

        // R10 idle
        acc(1'b0, 1'b1, 32'h2100_0000);
        chk("R10 idle sel", 32'(oh[0]), 32'h0);
        chk("R10 idle miss", 32'(ms[0]) | 32'(we_e[0]), 32'h0);

        // random traffic against the model
        for (int i = 0; i < 3000; i++) begin
            if (i % 16 == 0) begin
                int sel = $urandom_range(0, 5);
                logic [7:0] a = (sel == 5) ? 8'h00 : 8'(8'h30 + 4 * sel);
                wr(a, $urandom, $urandom & 32'h07F0_07F0);
            end
            acc(1'($urandom), 1'($urandom), BASE + 32'($urandom_range(0, 32'h02FF_FFFF)));
            if (i % 7 == 0) rsel(8'(8'h30 + 4 * $urandom_range(0, 5)));
        end

        run = 1'b0;
        finish_run();
    end

endmodule